// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a 32-bit bus master and an external bus whose
ports may be 8, 16 or 32 bits wide. The master hands over one operand of
one to four bytes with a start address, a direction and (for writes) the
data. The controller then runs as many bus cycles as the responding port
needs. On every cycle it presents the remaining byte count and the
current address, steers operand bytes onto fixed byte lanes for writes,
and waits for a two-bit port acknowledge that both ends the cycle and
tells it the width of the port that answered.

From that width and the two low address bits it works out how many bytes
the cycle moved, advances the address and shrinks the remaining count by
that number, and keeps issuing cycles until nothing is left. On reads the
bytes taken from each cycle are placed at their operand positions in an
internal register, and a one-cycle completion strobe is raised once the
last byte is in.

The sequencer has three states. `S_IDLE` waits for a request; the
*accept* transition (request valid while ready) leads to `S_CYCLE`. In
`S_CYCLE` a cycle is on the bus; an acknowledge that leaves bytes
outstanding takes the *continue* transition back into `S_CYCLE` with the
new address and count, and one that moves the last bytes takes the
*finish* transition to `S_DONE`. `S_DONE` raises the completion strobe
for one cycle and takes the *release* transition back to `S_IDLE`.

Top module: `dyn_bus_sizer`

## Requirements
- R1: The first bus cycle starts in the cycle after a request is accepted, with `bus_addr` equal to the request address and `bus_len` equal to the request length code; length codes are 01 = one byte, 10 = two, 11 = three, 00 = four, and `bus_len` always shows the bytes still outstanding in that same code.
- R2: Write lanes are named by position, lane 0 = bits 31:24 down to lane 3 = bits 7:0. With the outstanding bytes numbered B0 (first, most significant remaining operand byte) upward and a = `bus_addr[1:0]`: lane 0 carries B0; lane 1 carries B0 when a is odd and B1 when even; lane 2 and lane 3 (index k) carry B(k-a) when k >= a and zero otherwise; a byte index beyond the outstanding count reads as zero. A port of any width that stores its lanes therefore ends up with the operand at consecutive addresses.
- R3: `port_ack` decodes as 11 = 32-bit port, 10 = 16-bit port, 01 = 8-bit port, 00 = no acknowledge; while it is 00 the cycle is held with address and length unchanged.
- R4: An acknowledged cycle moves min(outstanding, w) bytes, where w is 4 - a for a 32-bit port, 2 - a[0] for a 16-bit port and 1 for an 8-bit port; the address advances and the outstanding count shrinks by that amount.
- R5: On reads, byte B(j) of a cycle is taken from lane a + j of a 32-bit port, lane a[0] + j of a 16-bit port, or lane 0 of an 8-bit port, and written to its operand position; operand bytes are right-justified in `rsp_rdata` (the last byte at bits 7:0) and unused upper bytes are zero.
- R6: `rsp_done` is high for exactly one cycle, the cycle after the acknowledge that moves the last byte, with `rsp_rdata` complete; `req_ready` returns the cycle after.
- R7: `req_ready` is high only in the idle state and never together with `bus_strobe`; a request presented while busy is ignored.
- R8: After synchronous reset `req_ready` is 1 and `bus_strobe`, `rsp_done` and `rsp_rdata` are 0.
- R9: The number of bus cycles per operand equals the count implied by R4, e.g. a four-byte operand at address offset 1 on a 16-bit port takes three cycles (1, 2, 1 bytes).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Operand length code (R1) |
| req_addr | input | ADDR_W | Operand start address |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Assembled read operand, right-justified |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Direction of the current cycle |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_len | output | 2 | Outstanding byte count code |
| bus_wdata | output | 32 | Write byte lanes |
| bus_rdata | input | 32 | Read byte lanes |
| port_ack | input | 2 | Cycle acknowledge and port width (R3) |

## Verification
A wrong outstanding count or address inside the controller shows at the
ports on the very next cycle, because `bus_len` and `bus_addr` present
those registers directly and are compared against a reference every
clock. A wrong step or lane choice on reads surfaces in `rsp_rdata` at the
cycle after the acknowledge that captured the byte, and a wrong write lane
corrupts the byte stored by the port model, seen when the operand
finishes. A sequencing fault (lost or extra cycle) shows as a mismatch in
`bus_strobe`, `rsp_done` or the per-operand cycle count.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int CNT_W  = $clog2(LANES) + 1;

    localparam logic [1:0] ACK_NONE = 2'b00;
    localparam logic [1:0] ACK_P8   = 2'b01;
    localparam logic [1:0] ACK_P16  = 2'b10;
    localparam logic [1:0] ACK_P32  = 2'b11;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CYCLE = 2'd1,
        S_DONE  = 2'd2
    } dbs_state_t;

    // Length code 00 stands for a full four-byte operand.
    function automatic logic [CNT_W-1:0] len_decode(input logic [1:0] code);
        return (code == 2'b00) ? CNT_W'(LANES) : CNT_W'(code);
    endfunction

endpackage

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
    import dbs_pkg::*;
(
    input  logic [1:0]       ack,
    input  logic [CNT_W-1:0] remain,
    input  logic [1:0]       offs,
    output logic [CNT_W-1:0] step,
    output logic [1:0]       base_lane
);
    logic [CNT_W-1:0] window;

    // Bytes the answering port can take from this offset, and the lane of
    // the first of them.
    always_comb begin
        window    = '0;
        base_lane = '0;
        unique case (ack)
            ACK_P32: begin
                window    = CNT_W'(LANES) - CNT_W'(offs);
                base_lane = offs;
            end
            ACK_P16: begin
                window    = CNT_W'(2) - CNT_W'(offs[0]);
                base_lane = {1'b0, offs[0]};
            end
            ACK_P8: begin
                window    = CNT_W'(1);
                base_lane = '0;
            end
            default: begin
                window    = '0;
                base_lane = '0;
            end
        endcase
        step = (window < remain) ? window : remain;
    end

endmodule

// File: rtl/dbs_lane_router.sv
module dbs_lane_router
    import dbs_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  remain,
    input  logic [1:0]        offs,
    output logic [DATA_W-1:0] lanes
);
    logic [BYTE_W-1:0] rb [LANES];
    logic [CNT_W-1:0]  skip;

    // rb[j] is the j-th outstanding operand byte; zero past the end.
    always_comb begin
        skip = CNT_W'(LANES) - remain;
        for (int j = 0; j < LANES; j++) begin
            if (int'(skip) + j < LANES)
                rb[j] = operand[DATA_W-1-BYTE_W*(int'(skip)+j) -: BYTE_W];
            else
                rb[j] = '0;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_first
            // narrowest port always reads the top lane
            assign lanes[DATA_W-1 -: BYTE_W] = rb[0];
        end else if (k == 1) begin : g_second
            // half-width port: odd offset starts on this lane
            assign lanes[DATA_W-1-BYTE_W -: BYTE_W] = offs[0] ? rb[0] : rb[1];
        end else begin : g_low
            assign lanes[DATA_W-1-BYTE_W*k -: BYTE_W] =
                (offs <= 2'(k)) ? rb[2'(k) - offs] : '0;
        end
    end

endmodule

// File: rtl/dbs_read_merge.sv
module dbs_read_merge
    import dbs_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CNT_W-1:0]  remain,
    input  logic [CNT_W-1:0]  step,
    input  logic [1:0]        base_lane,
    output logic [DATA_W-1:0] merged
);
    int idx;
    int lane;

    always_comb begin
        merged = cur;
        idx    = 0;
        lane   = 0;
        for (int j = 0; j < LANES; j++) begin
            if (CNT_W'(j) < step) begin
                idx  = LANES - int'(remain) + j;
                lane = int'(base_lane) + j;
                if (idx >= 0 && idx < LANES && lane < LANES)
                    merged[DATA_W-1-BYTE_W*idx -: BYTE_W] =
                        bus_data[DATA_W-1-BYTE_W*lane -: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_strobe,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_len,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        port_ack
);
    dbs_state_t        state, state_nx;
    logic [DATA_W-1:0] op_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] merged;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  step;
    logic [1:0]        base_lane;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic              accept;
    logic              moved;

    dbs_step_calc u_step (
        .ack       (port_ack),
        .remain    (remain_q),
        .offs      (addr_q[1:0]),
        .step      (step),
        .base_lane (base_lane)
    );

    dbs_lane_router u_route (
        .operand (op_q),
        .remain  (remain_q),
        .offs    (addr_q[1:0]),
        .lanes   (bus_wdata)
    );

    dbs_read_merge u_merge (
        .cur       (rdata_q),
        .bus_data  (bus_rdata),
        .remain    (remain_q),
        .step      (step),
        .base_lane (base_lane),
        .merged    (merged)
    );

    assign accept = (state == S_IDLE) && req_valid;
    assign moved  = (state == S_CYCLE) && (step != '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_CYCLE;          // accept
            S_CYCLE: if (moved && step == remain_q) state_nx = S_DONE; // finish
            S_DONE:  state_nx = S_IDLE;                          // release
            default: state_nx = S_IDLE;
        endcase
    end

    // Operand, address, count and read assembly registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            rdata_q  <= '0;
            remain_q <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
        end else if (accept) begin
            op_q     <= req_wdata;
            rdata_q  <= '0;
            remain_q <= len_decode(req_len);
            addr_q   <= req_addr;
            wr_q     <= req_write;
        end else if (moved) begin
            remain_q <= remain_q - step;
            addr_q   <= addr_q + ADDR_W'(step);
            if (!wr_q) rdata_q <= merged;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        bus_strobe = 1'b0;
        rsp_done   = 1'b0;
        unique case (state)
            S_IDLE:  req_ready  = 1'b1;
            S_CYCLE: bus_strobe = 1'b1;
            S_DONE:  rsp_done   = 1'b1;
            default: ;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_len   = remain_q[1:0];
    assign bus_write = wr_q;
    assign rsp_rdata = rdata_q;

    // Assertions
    assert_first_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (bus_strobe && bus_addr == $past(req_addr) && bus_len == $past(req_len)));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && port_ack == ACK_NONE) |=>
            (bus_strobe && $stable(bus_addr) && $stable(bus_len)));

    assert_byte_port_step_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && port_ack == ACK_P8 && bus_len != 2'b01) |=>
            (bus_strobe && bus_addr == $past(bus_addr) + ADDR_W'(1)
             && bus_len == $past(bus_len) - 2'd1));

    assert_full_port_done_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && port_ack == ACK_P32 && bus_addr[1:0] == 2'b00) |=> rsp_done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    assert_ready_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && bus_strobe));

endmodule

// File: tb/dyn_bus_sizer_test.sv
module dyn_bus_sizer_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_len = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_done;
    logic [31:0]   rsp_rdata;
    logic          bus_strobe;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_len;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [1:0]    port_ack = 2'b00;

    always #4 clk = ~clk;   // 125 MHz

    dyn_bus_sizer #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_len(req_len), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_ack(port_ack)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int pw     = 4;      // width in bytes of the responding port
    int wait_n = 0;
    int wctr   = 0;
    int acks   = 0;
    logic [7:0] mem [64];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Port model: read lanes by width, junk on unused lanes
    always_comb begin
        bus_rdata = 32'hEEEE_EEEE;
        for (int k = 0; k < 4; k++) begin
            if (pw == 4)
                bus_rdata[31-8*k -: 8] = mem[(int'(bus_addr[5:0]) & ~3) + k];
            else if (pw == 2 && k < 2)
                bus_rdata[31-8*k -: 8] = mem[(int'(bus_addr[5:0]) & ~1) + k];
            else if (pw == 1 && k == 0)
                bus_rdata[31:24] = mem[int'(bus_addr[5:0])];
        end
    end

    function automatic int ack_code(input int w);
        return (w == 4) ? 3 : (w == 2) ? 2 : 1;
    endfunction

    function automatic int port_step(input int w, input int n, input int a);
        int win;
        win = (w == 4) ? 4 - (a % 4) : (w == 2) ? 2 - (a % 2) : 1;
        return (win < n) ? win : n;
    endfunction

    // Acknowledge driver
    always @(posedge clk) begin
        #1;
        if (bus_strobe && port_ack == 2'b00 && wctr >= wait_n) begin
            port_ack = 2'(ack_code(pw));
            wctr = 0;
        end else begin
            if (bus_strobe && port_ack == 2'b00) wctr++;
            port_ack = 2'b00;
        end
    end

    // Reference model
    int mst = 0;  // 0 idle, 1 cycle, 2 done
    int mn = 0;
    int ma = 0;
    bit mw = 0;
    logic [7:0] mop [4];
    logic [7:0] mrd [4];
    bit s_rv, s_wr;
    logic [1:0] s_len, s_ack;
    logic [AW-1:0] s_addr;
    logic [31:0] s_wd, s_rd;

    function automatic logic [31:0] exp_lanes();
        logic [7:0] rb [4];
        logic [31:0] v;
        int a;
        a = ma % 4;
        for (int j = 0; j < 4; j++) rb[j] = (4 - mn + j < 4) ? mop[4 - mn + j] : 8'h00;
        v[31:24] = rb[0];
        v[23:16] = (a % 2 == 1) ? rb[0] : rb[1];
        for (int k = 2; k < 4; k++) v[31-8*k -: 8] = (k >= a) ? rb[k - a] : 8'h00;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mn = 0; ma = 0; mw = 0;
            for (int j = 0; j < 4; j++) begin mop[j] = 0; mrd[j] = 0; end
        end else begin
            case (mst)
                0: if (s_rv) begin
                    mst = 1; mw = s_wr; ma = int'(s_addr);
                    mn = (s_len == 2'b00) ? 4 : int'(s_len);
                    for (int j = 0; j < 4; j++) begin
                        mop[j] = s_wd[31-8*j -: 8]; mrd[j] = 0;
                    end
                end
                1: if (s_ack != 2'b00) begin
                    int w, c, base;
                    w = (s_ack == 2'b11) ? 4 : (s_ack == 2'b10) ? 2 : 1;
                    c = port_step(w, mn, ma);
                    base = (w == 4) ? ma % 4 : (w == 2) ? ma % 2 : 0;
                    if (!mw)
                        for (int j = 0; j < c; j++)
                            mrd[4 - mn + j] = s_rd[31-8*(base+j) -: 8];
                    mn = mn - c; ma = ma + c;
                    if (mn == 0) mst = 2;
                end
                default: mst = 0;
            endcase
        end
    end

    // Every-clock comparison, input snapshot, port store
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] erd;
            for (int j = 0; j < 4; j++) erd[31-8*j -: 8] = mrd[j];
            chk(req_ready == (mst == 0), "R7 ready", 64'(req_ready), 64'(mst == 0));
            chk(bus_strobe == (mst == 1), "R7 strobe", 64'(bus_strobe), 64'(mst == 1));
            chk(rsp_done == (mst == 2), "R6 done", 64'(rsp_done), 64'(mst == 2));
            chk(rsp_rdata == erd, "R5 rdata", 64'(rsp_rdata), 64'(erd));
            if (mst == 1) begin
                chk(bus_addr == AW'(ma), "R4 addr", 64'(bus_addr), 64'(ma));
                chk(bus_len == 2'(mn % 4), "R1 len code", 64'(bus_len), 64'(mn % 4));
                chk(bus_write == mw, "R7 dir", 64'(bus_write), 64'(mw));
                if (mw)
                    chk(bus_wdata == exp_lanes(), "R2 lanes", 64'(bus_wdata),
                        64'(exp_lanes()));
            end
        end
        if (bus_strobe && port_ack != 2'b00) begin
            int c, base, a;
            acks++;
            a = int'(bus_addr[5:0]);
            c = port_step(pw, (bus_len == 2'b00) ? 4 : int'(bus_len), a);
            base = (pw == 4) ? a % 4 : (pw == 2) ? a % 2 : 0;
            if (bus_write)
                for (int j = 0; j < c; j++) mem[(a + j) % 64] = bus_wdata[31-8*(base+j) -: 8];
        end
        s_rv = req_valid; s_wr = req_write; s_len = req_len; s_addr = req_addr;
        s_wd = req_wdata; s_ack = port_ack; s_rd = bus_rdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input int w, input int len, input int off, input bit wr,
                          input bit junk);
        logic [31:0] wd;
        int base_addr, n, a, ecyc;
        base_addr = 16 + off;
        wd = 32'hA1B2C3D4 ^ {8'(len), 8'(off), 8'(w), 8'(cyc)};
        do @(negedge clk); while (!req_ready);
        pw = w; wait_n = (len + off) % 3;
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_len = 2'(len % 4);
        req_addr = AW'(base_addr); req_wdata = wd;
        @(posedge clk); #1;
        acks = 0;
        if (junk) begin
            req_write = !wr; req_len = 2'b01; req_addr = AW'(40); req_wdata = 32'h5A5A5A5A;
            @(posedge clk); #1;
        end
        req_valid = 0;
        do @(negedge clk); while (!rsp_done);
        // R9: cycle count
        n = len; a = base_addr; ecyc = 0;
        while (n > 0) begin int c; c = port_step(w, n, a); n -= c; a += c; ecyc++; end
        chk(acks == ecyc, "R9 cycle count", 64'(acks), 64'(ecyc));
        if (wr) begin
            for (int j = 0; j < len; j++)
                chk(mem[base_addr + j] == wd[31-8*(4-len+j) -: 8], "R2 stored byte",
                    64'(mem[base_addr + j]), 64'(wd[31-8*(4-len+j) -: 8]));
        end else begin
            logic [31:0] er;
            er = '0;
            for (int j = 0; j < len; j++) er[31-8*(4-len+j) -: 8] = mem[base_addr + j];
            chk(rsp_rdata == er, "R5 assembled read", 64'(rsp_rdata), 64'(er));
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 reset ready", 64'(req_ready), 64'd1);
        chk(bus_strobe == 1'b0, "R8 reset strobe", 64'(bus_strobe), 64'd0);
        chk(rsp_done == 1'b0, "R8 reset done", 64'(rsp_done), 64'd0);
        chk(rsp_rdata == 32'd0, "R8 reset rdata", 64'(rsp_rdata), 64'd0);
        @(posedge clk); #1; rst = 0;
        // R1: first cycle address and length code
        @(posedge clk); #1;
        pw = 1; wait_n = 2;
        req_valid = 1; req_write = 0; req_len = 2'b11; req_addr = AW'(20); req_wdata = '0;
        @(posedge clk); #1; req_valid = 0;
        @(negedge clk);
        chk(bus_addr == AW'(20), "R1 first addr", 64'(bus_addr), 64'd20);
        chk(bus_len == 2'b11, "R1 first len", 64'(bus_len), 64'd3);
        // R3: held while no acknowledge
        @(negedge clk);
        chk(bus_strobe && bus_addr == AW'(20) && bus_len == 2'b11, "R3 wait hold",
            64'(bus_addr), 64'd20);
        do @(negedge clk); while (!rsp_done);
        // R9 named example: long word, offset 1, half-width port
        run_op(2, 4, 1, 0, 0);
        chk(acks == 3, "R9 three cycles", 64'(acks), 64'd3);
        for (int w = 1; w <= 4; w = w * 2)
            for (int len = 1; len <= 4; len++)
                for (int off = 0; off < 4; off++)
                    for (int wr = 0; wr < 2; wr++)
                        run_op(w, len, off, wr[0], (off == len % 4));  // R7 junk
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule